// File: doc/BRIEF.md
# Push-Pull Alternating Gate Generator

This block drives the two switches of a centre-tapped push-pull converter from the system clock. A switching period of `PERIOD_CLKS` clocks is split into two equal halves. Side A may conduct only in the first half and side B only in the second. In each half the active switch is on for the same number of clocks, taken from an external duty command, and stays off for the rest of that half. The on-time is held fixed for a whole period, so the transformer sees volt-seconds of equal size in both directions. The remainder of each half forms the dead interval before the other side turns on. The default of 1000 clocks gives a 50 kHz period at a 50 MHz clock.

A position counter runs freely from reset and marks every period boundary. Whenever `enable` is low the gates are forced off. When `enable` is high at a boundary, a new period starts: the duty command is clamped and latched, and `cycle_strobe` pulses so that the regulator can sample in step. The phase machine has five states. `PH_IDLE` is the off state. `PH_A_ON` and `PH_A_GAP` are the conducting and dead parts of the first half. `PH_B_ON` and `PH_B_GAP` are the same for the second half. The transitions are as follows. IDLE goes to A_ON, or to A_GAP for a zero command, at a boundary with enable high. A_ON goes to A_GAP after the latched on-time. A_GAP goes to B_ON, or B_GAP, at the mid-period point. B_ON goes to B_GAP after the same on-time. B_GAP goes back to A_ON or A_GAP at the next boundary. Every state goes to IDLE when enable is low.

Top module: `pp_gate_gen`

## Requirements
- R1: While enabled, `cycle_strobe` repeats every `PERIOD_CLKS` clocks, and `gate_b` rises exactly `PERIOD_CLKS/2` clocks after the first cycle of the period.
- R2: `gate_a` and `gate_b` are never high in the same clock cycle.
- R3: In each half the on-time in clocks equals the latched command, clamped to `PERIOD_CLKS/2 - GUARD`. With the defaults GUARD is 2, so the limit is 498 clocks; with a 64-clock period it is 30.
- R4: Within one period, the `gate_b` pulse is exactly as long as the `gate_a` pulse before it.
- R5: The gap between one gate falling and the other rising equals half the period minus the on-time, and it is never shorter than GUARD clocks. This holds after an enable drop as well.
- R6: A change of `duty_cmd` during a period has no effect until the next period boundary.
- R7: A zero command produces no gate pulses, but the period strobes continue.
- R8: During reset, and in the clock after any edge at which `enable` is sampled low, `gate_a`, `gate_b` and `cycle_strobe` are all low.
- R9: After `enable` rises, nothing is driven until the next free-running period boundary. The first period then starts with side A.
- R10: `cycle_strobe` is high for exactly one clock, which is the first clock of the period, and it coincides with the start of the `gate_a` pulse when the command is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces both gates off |
| duty_cmd | input | DUTY_W | Requested on-time per half, in clocks |
| gate_a | output | 1 | Drive for the first-half switch |
| gate_b | output | 1 | Drive for the second-half switch |
| cycle_strobe | output | 1 | One-clock pulse at each period start |

## Verification
The assertions assume that `enable` and `duty_cmd` are synchronous to `clk` and stable around each rising edge. They also assume that `PERIOD_CLKS` is even and larger than twice GUARD, because the on-time and gap checks rely on every pulse ending before the mid-period or boundary compare. The stimulus changes its inputs only on the falling clock edge and runs with a short 64-clock period. The random duty values go past the clamp limit, and enable is dropped at arbitrary positions, including inside a `gate_b` pulse, so the truncation and restart cases stay within those assumptions.

// File: rtl/pp_gate_pkg.sv
`timescale 1ns/1ps
package pp_gate_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_A_ON  = 3'd1,
        PH_A_GAP = 3'd2,
        PH_B_ON  = 3'd3,
        PH_B_GAP = 3'd4
    } phase_e;

endpackage

// File: rtl/pp_cycle_timer.sv
`timescale 1ns/1ps
module pp_cycle_timer #(
    parameter int HALF  = 500,
    parameter int SUB_W = $clog2(HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SUB_W-1:0] sub,
    output logic             mid_end,
    output logic             cyc_end
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF - 1);

    logic [SUB_W-1:0] sub_q;
    logic             second_q;
    logic             last_sub;

    assign last_sub = (sub_q == SUB_LAST);
    assign sub      = sub_q;
    assign mid_end  = last_sub && !second_q;
    assign cyc_end  = last_sub && second_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q    <= '0;
            second_q <= 1'b0;
        end else if (last_sub) begin
            sub_q    <= '0;
            second_q <= ~second_q;
        end else begin
            sub_q    <= sub_q + SUB_W'(1);
        end
    end

    // R1: the two half-ends alternate, so a period end follows the mid-point
    assert_half_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mid_end |=> !mid_end && !cyc_end);

endmodule

// File: rtl/pp_duty_hold.sv
`timescale 1ns/1ps
module pp_duty_hold #(
    parameter int HALF   = 500,
    parameter int GUARD  = 2,
    parameter int DUTY_W = 10,
    parameter int SUB_W  = $clog2(HALF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic              load,
    output logic [SUB_W-1:0]  clamped,
    output logic [SUB_W-1:0]  on_len
);

    localparam int MAX_ON = HALF - GUARD;
    localparam int WIDE   = (DUTY_W > SUB_W) ? DUTY_W : SUB_W;

    logic [WIDE-1:0] cmd_wide;

    assign cmd_wide = WIDE'(duty_cmd);

    always_comb begin
        if (cmd_wide > WIDE'(MAX_ON)) begin
            clamped = SUB_W'(MAX_ON);
        end else begin
            clamped = cmd_wide[SUB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_len <= '0;
        end else if (load) begin
            on_len <= clamped;
        end
    end

    // R6: the latched on-time only moves at a period start
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(on_len));

    // R3: the latched value never exceeds the guard-limited half period
    assert_clamp_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        on_len <= SUB_W'(MAX_ON));

endmodule

// File: rtl/pp_phase_fsm.sv
`timescale 1ns/1ps
module pp_phase_fsm
    import pp_gate_pkg::*;
#(
    parameter int HALF  = 500,
    parameter int GUARD = 2,
    parameter int SUB_W = $clog2(HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SUB_W-1:0] sub,
    input  logic             mid_end,
    input  logic             cyc_end,
    input  logic [SUB_W-1:0] clamped,
    input  logic [SUB_W-1:0] on_len,
    output logic             load,
    output logic             gate_a,
    output logic             gate_b,
    output logic             strobe
);

    localparam int MAX_ON = HALF - GUARD;
    localparam int LO_W   = $clog2(GUARD + 1) + 1;

    phase_e state, nxt;
    logic   on_end;
    phase_e a_entry;

    assign on_end  = (({1'b0, sub} + (SUB_W+1)'(1)) == {1'b0, on_len});
    assign a_entry = (clamped != '0) ? PH_A_ON : PH_A_GAP;

    // next-state logic
    always_comb begin
        nxt  = state;
        load = 1'b0;
        if (!enable) begin
            nxt = PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (cyc_end) begin
                        load = 1'b1;
                        nxt  = a_entry;
                    end
                end
                PH_A_ON: begin
                    if (on_end) nxt = PH_A_GAP;
                end
                PH_A_GAP: begin
                    if (mid_end) nxt = (on_len != '0) ? PH_B_ON : PH_B_GAP;
                end
                PH_B_ON: begin
                    if (on_end) nxt = PH_B_GAP;
                end
                PH_B_GAP: begin
                    if (cyc_end) begin
                        load = 1'b1;
                        nxt  = a_entry;
                    end
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_a <= 1'b0;
            gate_b <= 1'b0;
            strobe <= 1'b0;
        end else begin
            gate_a <= (nxt == PH_A_ON);
            gate_b <= (nxt == PH_B_ON);
            strobe <= load;
        end
    end

    // run-length history of the gate outputs, used by the checks below
    logic            prev_a, prev_b, prev_en;
    logic [SUB_W:0]  hi_run;
    logic [SUB_W:0]  a_len;
    logic [LO_W-1:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_a  <= 1'b0;
            prev_b  <= 1'b0;
            prev_en <= 1'b0;
            hi_run  <= '0;
            a_len   <= '0;
            lo_run  <= LO_W'(GUARD);
        end else begin
            prev_a  <= gate_a;
            prev_b  <= gate_b;
            prev_en <= enable;
            hi_run  <= (gate_a || gate_b) ? hi_run + (SUB_W+1)'(1) : '0;
            if (gate_a || gate_b)          lo_run <= '0;
            else if (lo_run < LO_W'(GUARD)) lo_run <= lo_run + LO_W'(1);
            if (prev_a && !gate_a)         a_len  <= hi_run;
        end
    end

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a && gate_b));

    assert_on_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= (SUB_W+1)'(MAX_ON));

    assert_match_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_b && !gate_b && prev_en) |-> (hi_run == a_len));

    assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_a && !prev_a) || (gate_b && !prev_b)) |-> (lo_run >= LO_W'(GUARD)));

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_a && !gate_b && !strobe));

    assert_b_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_b && !prev_b) |-> (sub == '0));

    assert_strobe_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (gate_a == (on_len != '0)));

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    assert_a_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a && !prev_a) |-> strobe);

endmodule

// File: rtl/pp_gate_gen.sv
`timescale 1ns/1ps
module pp_gate_gen #(
    parameter int PERIOD_CLKS = 1000,
    parameter int GUARD       = 2,
    parameter int DUTY_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic              gate_a,
    output logic              gate_b,
    output logic              cycle_strobe
);

    localparam int HALF  = PERIOD_CLKS / 2;
    localparam int SUB_W = $clog2(HALF);

    logic [SUB_W-1:0] sub;
    logic             mid_end;
    logic             cyc_end;
    logic [SUB_W-1:0] clamped;
    logic [SUB_W-1:0] on_len;
    logic             load;

    pp_cycle_timer #(
        .HALF  (HALF),
        .SUB_W (SUB_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub     (sub),
        .mid_end (mid_end),
        .cyc_end (cyc_end)
    );

    pp_duty_hold #(
        .HALF   (HALF),
        .GUARD  (GUARD),
        .DUTY_W (DUTY_W),
        .SUB_W  (SUB_W)
    ) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_cmd (duty_cmd),
        .load     (load),
        .clamped  (clamped),
        .on_len   (on_len)
    );

    pp_phase_fsm #(
        .HALF  (HALF),
        .GUARD (GUARD),
        .SUB_W (SUB_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .sub     (sub),
        .mid_end (mid_end),
        .cyc_end (cyc_end),
        .clamped (clamped),
        .on_len  (on_len),
        .load    (load),
        .gate_a  (gate_a),
        .gate_b  (gate_b),
        .strobe  (cycle_strobe)
    );

endmodule

// File: tb/sim_pp_gate_gen.sv
`timescale 1ns/1ps
module sim_pp_gate_gen;

    localparam int P  = 64;
    localparam int G  = 2;
    localparam int DW = 8;
    localparam int H  = P / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] duty = '0;
    logic          gate_a, gate_b, strobe;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R8";

    always #10 clk = ~clk;

    pp_gate_gen #(.PERIOD_CLKS(P), .GUARD(G), .DUTY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(en), .duty_cmd(duty),
        .gate_a(gate_a), .gate_b(gate_b), .cycle_strobe(strobe)
    );

    function automatic int clamp_on(input int d);
        return (d > H - G) ? H - G : d;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // reference model built from the requirements
    int m_pos = 0, m_on = 0;
    bit m_active = 0, m_en = 0, en_gap_low = 1;

    always @(posedge clk) begin
        m_en = en;
        if (!rst_n) begin
            m_pos = 0; m_active = 0; m_on = 0;
        end else begin
            if (!en) begin
                m_active = 0; en_gap_low = 1;
            end else if (m_pos == P - 1) begin
                m_active = 1; m_on = clamp_on(int'(duty));
            end
            m_pos = (m_pos == P - 1) ? 0 : m_pos + 1;
        end
    end

    // output monitor
    bit pa = 0, pb = 0, have_s = 0;
    int a_run = 0, b_run = 0, last_a = 0, since_fall = 0, s_gap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ea, eb, es;
            string gt;
            ea = m_active && m_pos < H && m_pos < m_on;
            eb = m_active && m_pos >= H && (m_pos - H) < m_on;
            es = m_active && m_pos == 0;
            gt = m_en ? cur_req : "R8";
            check(gt, int'(gate_a), int'(ea));
            check(gt, int'(gate_b), int'(eb));
            check("R10", int'(strobe), int'(es));
            check("R2", int'(gate_a && gate_b), 0);
            // R5: dead interval before side B
            if (gate_b && !pb && m_en) check("R5", since_fall, H - m_on);
            // R4: matched pulse widths
            if (!gate_b && pb && m_en) check("R4", b_run, last_a);
            // R1: period spacing of strobes
            if (strobe) begin
                if (have_s && !en_gap_low) check("R1", s_gap, P);
                have_s = 1; en_gap_low = 0; s_gap = 0;
            end
            s_gap++;
            if (pa && !gate_a) begin last_a = a_run; since_fall = 1; end
            else if (!gate_a) since_fall++;
            a_run = gate_a ? a_run + 1 : 0;
            b_run = gate_b ? b_run + 1 : 0;
            pa = gate_a; pb = gate_b;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E);
        // R8: outputs low in reset
        wait_cycles(5);
        check("R8", int'({gate_a, gate_b, strobe}), 0);
        rst_n = 1'b1;
        // R9: start at the next boundary
        cur_req = "R9"; duty = 8'd10; en = 1'b1;
        wait_cycles(3 * P);
        // R3: plain, exact-limit and clamped commands
        cur_req = "R3"; duty = 8'd25;  wait_cycles(2 * P);
        duty = 8'd30;  wait_cycles(2 * P);
        duty = 8'd31;  wait_cycles(2 * P);
        duty = 8'd200; wait_cycles(2 * P);
        // R5: minimum gap and short pulses
        cur_req = "R5"; duty = 8'd1; wait_cycles(2 * P);
        duty = 8'd29; wait_cycles(2 * P);
        // R7: zero command
        cur_req = "R7"; duty = 8'd0; wait_cycles(3 * P);
        // R6: command changed mid-period
        cur_req = "R6"; duty = 8'd12; wait_cycles(P + 7);
        duty = 8'd27; wait_cycles(H);
        duty = 8'd3;  wait_cycles(2 * P);
        // R8: disable inside a B pulse, then fast re-enable (R5 gap)
        cur_req = "R8"; duty = 8'd20;
        while (!gate_b) @(negedge clk);
        wait_cycles(4);
        en = 1'b0; wait_cycles(1);
        cur_req = "R9"; en = 1'b1; wait_cycles(3 * P);
        en = 1'b0; cur_req = "R8"; wait_cycles(100);
        en = 1'b1; cur_req = "R9"; wait_cycles(2 * P);
        // R1: random commands and enable drops
        cur_req = "R1";
        for (int i = 0; i < 40; i++) begin
            duty = DW'($urandom_range(0, 40));
            en   = ($urandom_range(0, 7) != 0);
            wait_cycles($urandom_range(5, 150));
        end
        en = 1'b1; duty = 8'd14; wait_cycles(3 * P);
        summary();
    end

endmodule